// File: doc/BRIEF.md
# Load-Store Scaled Address Generator

This block forms the effective address of a word or unsigned-byte memory access. It works only from its current inputs and holds no state. It combines a 32-bit base value with an offset and either adds the offset to the base or subtracts it. The offset can come from one of four sources:

- a 12-bit unsigned immediate;
- nothing, which gives an offset of zero;
- the full index register value;
- the index register passed through a barrel shifter. The shifter offers logical left, logical right, arithmetic right, rotate right, and a one-bit rotate right through the carry flag.

The block also drives the offset it selected on its own output. An indexing stage outside the block can use that value for base update. Writeback and the memory access itself are handled elsewhere.

Top module: `agen_ls_addr`

## Requirements
- R1: With `mode_i` = 0 (immediate), the offset is `imm_i` zero-extended to 32 bits. `offset_o` shows that value, and `addr_o` is base plus or minus it.
- R2: With `mode_i` = 1 (zero offset), `addr_o` equals `base_i` and `offset_o` is 0. `index_i`, `imm_i`, `add_i`, the shift fields and `carry_i` have no effect.
- R3: With `mode_i` = 2 (register), the offset is `index_i` unmodified. The shift fields and `carry_i` have no effect.
- R4: With `mode_i` = 3 (scaled), `shift_kind_i` picks the shift applied to `index_i` by `shift_amt_i`. The encodings are 0 = logical left, 1 = logical right, 2 = arithmetic right and 3 = rotate right. A logical left shift by 0 leaves the value unchanged.
- R5: A scaled logical right shift with `shift_amt_i` = 0 acts as a shift of 32, so the offset is 0.
- R6: A scaled arithmetic right shift with `shift_amt_i` = 0 acts as a shift of 32. Every offset bit then equals `index_i[31]`.
- R7: A scaled rotate right with `shift_amt_i` = 0 is a rotate right by one through carry. The offset is `{carry_i, index_i[31:1]}`.
- R8: `carry_i` affects the outputs only in the case of R7.
- R9: `add_i` = 1 adds the offset to the base and `add_i` = 0 subtracts it. Results wrap modulo 2^32 and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | 12 | Unsigned immediate offset |
| add_i | input | 1 | 1 = add offset, 0 = subtract offset |
| mode_i | input | 2 | Offset source: 0 imm, 1 zero, 2 register, 3 scaled |
| shift_kind_i | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR/RRX |
| shift_amt_i | input | 5 | Shift amount |
| carry_i | input | 1 | Carry flag, used only by RRX |
| addr_o | output | 32 | Effective address |
| offset_o | output | 32 | Offset selected before add/subtract |

## Verification
The bound checker watches the following whenever the inputs settle:

- In zero mode, the address equals the base.
- An immediate offset never has bits above the immediate width.
- The three zero-amount shift encodings produce their special results.
- The address always equals the base plus or minus the reported offset.

Only the bench scenarios can show that each nonzero shift amount and kind moves bits to the right place. The same holds for wrap-around at both ends of the address space, and for ignored inputs such as the carry flag outside RRX or the index in immediate mode leaving the outputs unchanged.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    OFS_IMM    = 2'd0,
    OFS_ZERO   = 2'd1,
    OFS_REG    = 2'd2,
    OFS_SCALED = 2'd3
  } ofs_mode_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/agen_index_shifter.sv
module agen_index_shifter
  import agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] value_i,
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] value_o
);
  localparam logic [AMT_W-1:0] AMT_ZERO = '0;

  logic                  amt_is_zero;
  logic [2*DATA_W-1:0]   doubled;
  logic [2*DATA_W-1:0]   rotated_wide;
  logic [DATA_W-1:0]     lsl_res;
  logic [DATA_W-1:0]     lsr_res;
  logic [DATA_W-1:0]     asr_res;
  logic [DATA_W-1:0]     ror_res;

  assign amt_is_zero  = (amt_i == AMT_ZERO);
  assign doubled      = {value_i, value_i};
  assign rotated_wide = doubled >> amt_i;

  always_comb begin
    lsl_res = value_i << amt_i;
    // zero amount encodes a full-width shift for the right shifts
    if (amt_is_zero) begin
      lsr_res = '0;
      asr_res = {DATA_W{value_i[DATA_W-1]}};
      ror_res = {carry_i, value_i[DATA_W-1:1]};
    end else begin
      lsr_res = value_i >> amt_i;
      asr_res = DATA_W'($signed(value_i) >>> amt_i);
      ror_res = rotated_wide[DATA_W-1:0];
    end
  end

  always_comb begin
    unique case (kind_i)
      SH_LSL:  value_o = lsl_res;
      SH_LSR:  value_o = lsr_res;
      SH_ASR:  value_o = asr_res;
      default: value_o = ror_res;
    endcase
  end
endmodule

// File: rtl/agen_offset_select.sv
module agen_offset_select
  import agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  ofs_mode_e         mode_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic [DATA_W-1:0] shifted_i,
  output logic [DATA_W-1:0] offset_o
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_zext
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (mode_i)
      OFS_IMM:  offset_o = imm_ext;
      OFS_ZERO: offset_o = '0;
      OFS_REG:  offset_o = index_i;
      default:  offset_o = shifted_i;
    endcase
  end
endmodule

// File: rtl/agen_addsub.sv
module agen_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic              add_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] operand;

  // two's complement subtract through one adder: invert and carry in
  assign operand = add_i ? offset_i : ~offset_i;
  assign sum_o   = base_i + operand + {{(DATA_W-1){1'b0}}, ~add_i};
endmodule

// File: rtl/agen_ls_addr.sv
module agen_ls_addr
  import agen_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int AMT_W  = 5
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              add_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        shift_kind_i,
  input  logic [AMT_W-1:0]  shift_amt_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] offset_o
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] offset;
  logic              eff_add;

  agen_index_shifter #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .value_i (index_i),
    .kind_i  (shift_kind_e'(shift_kind_i)),
    .amt_i   (shift_amt_i),
    .carry_i (carry_i),
    .value_o (shifted)
  );

  agen_offset_select #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .mode_i    (ofs_mode_e'(mode_i)),
    .imm_i     (imm_i),
    .index_i   (index_i),
    .shifted_i (shifted),
    .offset_o  (offset)
  );

  // with a zero offset the direction bit cannot matter; force add
  assign eff_add = add_i | (mode_i == OFS_ZERO);

  agen_addsub #(.DATA_W(DATA_W)) u_add (
    .base_i   (base_i),
    .offset_i (offset),
    .add_i    (eff_add),
    .sum_o    (addr_o)
  );

  assign offset_o = offset;
endmodule

// File: rtl/agen_ls_addr_chk.sv
module agen_ls_addr_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int AMT_W  = 5
) (
  input logic [DATA_W-1:0] base_i,
  input logic [DATA_W-1:0] index_i,
  input logic              add_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        shift_kind_i,
  input logic [AMT_W-1:0]  shift_amt_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] addr_o,
  input logic [DATA_W-1:0] offset_o
);
  logic known;
  logic scaled_zero_amt;

  assign known = !$isunknown({base_i, index_i, add_i, mode_i, shift_kind_i,
                              shift_amt_i, carry_i, addr_o, offset_o});
  assign scaled_zero_amt = (mode_i == 2'd3) && (shift_amt_i == '0);

  always_comb begin
    if (known) begin
      if (mode_i == 2'd1)
        assert_zero_mode_base_R2: assert (addr_o == base_i && offset_o == '0);
      if (mode_i == 2'd0)
        assert_imm_width_R1: assert (offset_o >> IMM_W == '0);
      if (scaled_zero_amt && shift_kind_i == 2'd1)
        assert_lsr_full_R5: assert (offset_o == '0);
      if (scaled_zero_amt && shift_kind_i == 2'd2)
        assert_asr_fill_R6: assert (offset_o == {DATA_W{index_i[DATA_W-1]}});
      if (scaled_zero_amt && shift_kind_i == 2'd3)
        assert_rrx_R7: assert (offset_o == {carry_i, index_i[DATA_W-1:1]});
      assert_sum_rel_R9: assert (addr_o == (add_i ? base_i + offset_o
                                                  : base_i - offset_o));
    end
  end
endmodule

bind agen_ls_addr agen_ls_addr_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_chk (
  .base_i       (base_i),
  .index_i      (index_i),
  .add_i        (add_i),
  .mode_i       (mode_i),
  .shift_kind_i (shift_kind_i),
  .shift_amt_i  (shift_amt_i),
  .carry_i      (carry_i),
  .addr_o       (addr_o),
  .offset_o     (offset_o)
);

// File: tb/sim_agen_ls_addr.sv
module sim_agen_ls_addr;
  typedef struct packed {
    logic [31:0] base;
    logic [31:0] index;
    logic [11:0] imm;
    logic        add;
    logic [1:0]  mode;
    logic [1:0]  kind;
    logic [4:0]  amt;
    logic        carry;
    logic [31:0] exp_addr;
    logic [31:0] exp_off;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    // base        index        imm    add  mode kind amt  c   addr         offset       req
    '{32'h00001000, 32'h0,       12'h123, 1'b1, 2'd0, 2'd0, 5'd0,  1'b0, 32'h00001123, 32'h00000123, 4'd1}, // R1
    '{32'h00001000, 32'h0,       12'hFFF, 1'b0, 2'd0, 2'd0, 5'd0,  1'b0, 32'h00000001, 32'h00000FFF, 4'd1}, // R1
    '{32'hDEADBEEF, 32'h55,      12'h077, 1'b0, 2'd1, 2'd2, 5'd3,  1'b1, 32'hDEADBEEF, 32'h00000000, 4'd2}, // R2
    '{32'h00000010, 32'h20,      12'h0,   1'b1, 2'd2, 2'd1, 5'd4,  1'b1, 32'h00000030, 32'h00000020, 4'd3}, // R3
    '{32'h00000010, 32'h20,      12'h0,   1'b0, 2'd2, 2'd3, 5'd0,  1'b1, 32'hFFFFFFF0, 32'h00000020, 4'd9}, // R9
    '{32'h00004000, 32'h3,       12'h0,   1'b1, 2'd3, 2'd0, 5'd2,  1'b0, 32'h0000400C, 32'h0000000C, 4'd4}, // R4
    '{32'h00000100, 32'h80000000,12'h0,   1'b1, 2'd3, 2'd1, 5'd4,  1'b0, 32'h08000100, 32'h08000000, 4'd4}, // R4
    '{32'h00001234, 32'hFFFFFFFF,12'h0,   1'b1, 2'd3, 2'd1, 5'd0,  1'b0, 32'h00001234, 32'h00000000, 4'd5}, // R5
    '{32'h00000010, 32'h80000000,12'h0,   1'b1, 2'd3, 2'd2, 5'd0,  1'b0, 32'h0000000F, 32'hFFFFFFFF, 4'd6}, // R6
    '{32'h00000000, 32'h80000000,12'h0,   1'b0, 2'd3, 2'd2, 5'd4,  1'b0, 32'h08000000, 32'hF8000000, 4'd4}, // R4
    '{32'h00000050, 32'h7FFFFFFF,12'h0,   1'b1, 2'd3, 2'd2, 5'd0,  1'b1, 32'h00000050, 32'h00000000, 4'd6}, // R6
    '{32'h00000001, 32'h000000AB,12'h0,   1'b1, 2'd3, 2'd3, 5'd8,  1'b0, 32'hAB000001, 32'hAB000000, 4'd4}, // R4
    '{32'h00000000, 32'h00000003,12'h0,   1'b1, 2'd3, 2'd3, 5'd0,  1'b1, 32'h80000001, 32'h80000001, 4'd7}, // R7
    '{32'h00000100, 32'h00000003,12'h0,   1'b0, 2'd3, 2'd3, 5'd0,  1'b0, 32'h000000FF, 32'h00000001, 4'd7}, // R7
    '{32'h80000000, 32'h00000003,12'h0,   1'b1, 2'd3, 2'd0, 5'd31, 1'b0, 32'h00000000, 32'h80000000, 4'd9}, // R9
    '{32'h00000000, 32'h00000001,12'h0,   1'b1, 2'd3, 2'd0, 5'd1,  1'b1, 32'h00000002, 32'h00000002, 4'd8}, // R8
    '{32'h00000000, 32'h00000003,12'h0,   1'b1, 2'd3, 2'd3, 5'd1,  1'b0, 32'h80000001, 32'h80000001, 4'd4}  // R4
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] base_i, index_i, addr_o, offset_o;
  logic [11:0] imm_i;
  logic        add_i, carry_i;
  logic [1:0]  mode_i, shift_kind_i;
  logic [4:0]  shift_amt_i;
  int          n_checks, n_fail;
  logic        done;

  agen_ls_addr u0 (
    .base_i(base_i), .index_i(index_i), .imm_i(imm_i), .add_i(add_i),
    .mode_i(mode_i), .shift_kind_i(shift_kind_i), .shift_amt_i(shift_amt_i),
    .carry_i(carry_i), .addr_o(addr_o), .offset_o(offset_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] a_exp, input logic [31:0] o_exp);
    n_checks++;
    if (addr_o !== a_exp || offset_o !== o_exp) begin
      n_fail++;
      $display("FAIL %s: addr=%h off=%h expected addr=%h off=%h", tag, addr_o, offset_o, a_exp, o_exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(posedge clk);
    base_i = v.base; index_i = v.index; imm_i = v.imm; add_i = v.add;
    mode_i = v.mode; shift_kind_i = v.kind; shift_amt_i = v.amt; carry_i = v.carry;
    @(negedge clk);
  endtask

  initial begin
    done = 1'b0; n_checks = 0; n_fail = 0; rst_n = 1'b0;
    base_i = '0; index_i = '0; imm_i = '0; add_i = 1'b0;
    mode_i = '0; shift_kind_i = '0; shift_amt_i = '0; carry_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 reset-state all-zero inputs", 32'h0, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].exp_addr, TBL[i].exp_off);
    end

    // R2: zero mode unaffected by index, immediate, direction, shift, carry
    for (int k = 0; k < 4; k++) begin
      drive('{32'h12345678, 32'hA5A5A5A5 ^ k, 12'(k * 301), k[0], 2'd1, 2'(k), 5'(k * 7), k[1],
              32'h0, 32'h0, 4'd2});
      check("R2 zero mode ignores other inputs", 32'h12345678, 32'h0);
    end
    // R1/R3: immediate mode ignores index and shift fields
    drive('{32'h00000200, 32'hFFFF0000, 12'h010, 1'b1, 2'd0, 2'd3, 5'd0, 1'b1, 32'h0, 32'h0, 4'd1});
    check("R1 imm mode ignores index", 32'h00000210, 32'h00000010);
    // R3: register mode ignores shift kind, amount and carry
    drive('{32'h00000000, 32'h80000001, 12'h0, 1'b1, 2'd2, 2'd3, 5'd0, 1'b1, 32'h0, 32'h0, 4'd3});
    check("R3 reg mode ignores shift fields", 32'h80000001, 32'h80000001);
    // R9: add wraps past the top
    drive('{32'hFFFFFFF0, 32'h00000020, 12'h0, 1'b1, 2'd2, 2'd0, 5'd0, 1'b0, 32'h0, 32'h0, 4'd9});
    check("R9 add wraps", 32'h00000010, 32'h00000020);
    // R8: carry has no effect on ASR amount 0
    drive('{32'h0, 32'h40000000, 12'h0, 1'b1, 2'd3, 2'd2, 5'd0, 1'b1, 32'h0, 32'h0, 4'd8});
    check("R8 carry ignored for ASR", 32'h0, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule